// File: doc/BRIEF.md
# Two-Byte Accumulator Processor

This block is a small multi-cycle processor built around an 8-bit accumulator, an index register, a stack pointer and a three-flag status byte (carry, zero, negative). Code and data sit together in one 256-byte memory inside the block. Every instruction takes two bytes: an opcode and then an operand. For implied operations the operand byte is skipped over. For memory operations it is an address. For immediate operations it is a value. For conditional branches it is a signed displacement.

A host fills the memory through a valid/ready image port while reset is held. It then releases reset and waits for `halted`. Execution begins at address 0. Once the core stops, the image port opens again. The host reads back memory through `img_rdata` and reads the architectural registers on plain observation pins. The port applies back-pressure by holding `img_ready` low for as long as the core runs. A write is taken only on a clock edge where `img_valid` and `img_ready` are both high. Any request presented while `img_ready` is low is dropped, not queued.

Top module: `acc8_cpu`

## Requirements
- R1: While reset is low the registers read A=00h, X=00h, SP=FFh, status=00h, with `halted` low and `img_ready` high. After release, the first opcode is fetched from address 0 and `img_ready` drops at once.
- R2: `img_ready` is high exactly while reset is held or the core is halted. A write happens only when `img_valid` and `img_ready` are both high. Requests made while the core runs change no memory. `img_rdata` always shows the byte at `img_addr`.
- R3: Each instruction is an opcode byte followed by an operand byte. Opcode bits 7:2 name the operation and bits 1:0 name the mode (00 direct, 01 indirect, 10 indexed, 11 immediate). Implied operations ignore their operand byte. The PC wraps modulo 256.
- R4: Direct mode uses the operand as the address. Indirect mode uses the byte stored at the operand address as the address. Indexed mode uses operand+X, modulo 256. Immediate mode uses the operand as the value.
- R5: ADC computes A+M+C. SBC computes A+~M+C, so a clear carry means a borrow. Both set C from the carry out and set Z and N from the result.
- R6: CMP sets C (A>=M), Z and N from A-M and leaves A unchanged.
- R7: AND, OR, loads, and memory INC and DEC set Z and N from their result and leave C alone. Stores leave all flags unchanged.
- R8: BCC, BCS, BEQ, BNE, BMI and BPL, when taken, load PC with (opcode address+2) plus the sign-extended operand. When not taken, execution continues at the next instruction. JMP loads PC with the operand.
- R9: JSR pushes the address of the following instruction and jumps to the operand. RTS pulls that address into PC.
- R10: A push writes memory at SP and then decrements SP. A pull increments SP and then reads. PHA and PLA move A, and PLA also sets Z and N. PHP and PLP move the status byte laid out as bit 7 N, bit 1 Z, bit 0 C, other bits zero.
- R11: TAX, TXA and TSX copy a register and set Z and N. TXS copies X to SP and leaves the flags alone. INCX and DECX step X and set Z and N.
- R12: Opcode 00h, every opcode with bits 7:2 above 31, and store, INC or DEC in immediate mode all stop the core. The core then holds `halted` and all of its state until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| img_valid | input | 1 | Write request on the image port |
| img_ready | output | 1 | Image port can accept a write |
| img_addr | input | 8 | Address for image write and readback |
| img_wdata | input | 8 | Byte to write |
| img_rdata | output | 8 | Memory byte at img_addr |
| halted | output | 1 | Core has stopped |
| acc_q | output | 8 | Accumulator |
| idx_q | output | 8 | Index register |
| sp_q | output | 8 | Stack pointer |
| psr_q | output | 8 | Status byte (N bit 7, Z bit 1, C bit 0) |

## Verification
Two things can happen in the same cycle: a host write request arriving at the image port, and the core's own memory accesses, including its stores and pushes. The bench holds `img_valid` high with a foreign byte aimed at an unused address for several cycles just after reset is released, while the program is fetching and pushing. After the halt it reads that address back and expects the byte still cleared. A second case puts the halt itself and a later host write next to each other, then checks that the write lands once the core has stopped.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam logic [DW-1:0] SP_INIT = 8'hFF;

  localparam int PSR_C = 0;
  localparam int PSR_Z = 1;
  localparam int PSR_N = 7;

  localparam logic [1:0] MODE_DIR = 2'b00;
  localparam logic [1:0] MODE_IND = 2'b01;
  localparam logic [1:0] MODE_IDX = 2'b10;
  localparam logic [1:0] MODE_IMM = 2'b11;

  localparam logic [5:0] OP_HLT  = 6'd0;
  localparam logic [5:0] OP_LDA  = 6'd1;
  localparam logic [5:0] OP_LDX  = 6'd2;
  localparam logic [5:0] OP_STA  = 6'd3;
  localparam logic [5:0] OP_ADC  = 6'd4;
  localparam logic [5:0] OP_SBC  = 6'd5;
  localparam logic [5:0] OP_AND  = 6'd6;
  localparam logic [5:0] OP_OR   = 6'd7;
  localparam logic [5:0] OP_CMP  = 6'd8;
  localparam logic [5:0] OP_INC  = 6'd9;
  localparam logic [5:0] OP_DEC  = 6'd10;
  localparam logic [5:0] OP_INCX = 6'd11;
  localparam logic [5:0] OP_DECX = 6'd12;
  localparam logic [5:0] OP_TAX  = 6'd13;
  localparam logic [5:0] OP_TXA  = 6'd14;
  localparam logic [5:0] OP_TSX  = 6'd15;
  localparam logic [5:0] OP_TXS  = 6'd16;
  localparam logic [5:0] OP_PHA  = 6'd17;
  localparam logic [5:0] OP_PLA  = 6'd18;
  localparam logic [5:0] OP_PHP  = 6'd19;
  localparam logic [5:0] OP_PLP  = 6'd20;
  localparam logic [5:0] OP_CLC  = 6'd21;
  localparam logic [5:0] OP_SEC  = 6'd22;
  localparam logic [5:0] OP_JMP  = 6'd23;
  localparam logic [5:0] OP_JSR  = 6'd24;
  localparam logic [5:0] OP_RTS  = 6'd25;
  localparam logic [5:0] OP_BCC  = 6'd26;
  localparam logic [5:0] OP_BCS  = 6'd27;
  localparam logic [5:0] OP_BEQ  = 6'd28;
  localparam logic [5:0] OP_BNE  = 6'd29;
  localparam logic [5:0] OP_BMI  = 6'd30;
  localparam logic [5:0] OP_BPL  = 6'd31;

  typedef enum logic [2:0] {
    ST_FETCH_OP,
    ST_FETCH_OPD,
    ST_DECODE,
    ST_INDIR,
    ST_EXEC,
    ST_PULL,
    ST_HALT
  } cpu_state_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_CMP,
    ALU_AND,
    ALU_OR,
    ALU_INC,
    ALU_DEC
  } alu_fn_e;
endpackage

// File: rtl/acc8_mem.sv
module acc8_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [AW-1:0] ext_addr,
  input  logic          ext_we,
  input  logic [DW-1:0] ext_wdata,
  output logic [DW-1:0] ext_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (ext_we) cells[ext_addr] <= ext_wdata;
    else if (cpu_we) cells[cpu_addr] <= cpu_wdata;
  end

  assign cpu_rdata = cells[cpu_addr];
  assign ext_rdata = cells[ext_addr];

  // the host port and the core never write in the same cycle
  assert_single_writer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_we && cpu_we));
endmodule

// File: rtl/acc8_alu.sv
module acc8_alu import acc8_pkg::*; #(
  parameter int W = 8
) (
  input  alu_fn_e       fn,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  logic [W:0] sum;

  always_comb begin
    sum  = '0;
    res  = b;
    cout = cin;
    unique case (fn)
      ALU_PASS: res = b;
      ALU_ADD: begin
        sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        res  = sum[W-1:0];
        cout = sum[W];
      end
      ALU_SUB: begin
        sum  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
        res  = sum[W-1:0];
        cout = sum[W];
      end
      ALU_CMP: begin
        sum  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        res  = sum[W-1:0];
        cout = sum[W];
      end
      ALU_AND: res = a & b;
      ALU_OR:  res = a | b;
      ALU_INC: res = b + {{(W-1){1'b0}}, 1'b1};
      ALU_DEC: res = b - {{(W-1){1'b0}}, 1'b1};
      default: res = b;
    endcase
  end
endmodule

// File: rtl/acc8_branch.sv
module acc8_branch import acc8_pkg::*; #(
  parameter int W = 8
) (
  input  logic [5:0]   op,
  input  logic         flag_c,
  input  logic         flag_z,
  input  logic         flag_n,
  input  logic [W-1:0] pc_next,
  input  logic [W-1:0] offset,
  output logic         taken,
  output logic [W-1:0] target
);
  always_comb begin
    unique case (op)
      OP_BCC:  taken = !flag_c;
      OP_BCS:  taken = flag_c;
      OP_BEQ:  taken = flag_z;
      OP_BNE:  taken = !flag_z;
      OP_BMI:  taken = flag_n;
      OP_BPL:  taken = !flag_n;
      default: taken = 1'b0;
    endcase
  end

  // two's-complement displacement: a plain modulo add of the byte
  assign target = pc_next + offset;
endmodule

// File: rtl/acc8_cpu.sv
module acc8_cpu import acc8_pkg::*; (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         img_valid,
  output logic         img_ready,
  input  logic [7:0]   img_addr,
  input  logic [7:0]   img_wdata,
  output logic [7:0]   img_rdata,
  output logic         halted,
  output logic [7:0]   acc_q,
  output logic [7:0]   idx_q,
  output logic [7:0]   sp_q,
  output logic [7:0]   psr_q
);
  cpu_state_e    state;
  logic [DW-1:0] pc, ir, opd, ea, a_r, x_r, sp_r;
  logic          fc, fz, fn;

  logic [5:0]    op;
  logic [1:0]    mode;
  logic [DW-1:0] psr;

  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wd, mem_rd;

  alu_fn_e       alu_fn;
  logic [DW-1:0] alu_b, alu_res;
  logic          alu_c;

  logic          br_taken;
  logic [DW-1:0] br_target;

  logic          is_read, is_rmw, commit_rd, res_zero;

  assign op   = ir[7:2];
  assign mode = ir[1:0];
  assign psr  = {fn, 5'b0, fz, fc};

  assign halted    = (state == ST_HALT);
  assign img_ready = !rst_n || halted;
  assign acc_q = a_r;
  assign idx_q = x_r;
  assign sp_q  = sp_r;
  assign psr_q = psr;

  assign is_read = (op == OP_LDA) || (op == OP_LDX) || (op == OP_ADC) || (op == OP_SBC) ||
                   (op == OP_AND) || (op == OP_OR)  || (op == OP_CMP);
  assign is_rmw  = (op == OP_INC) || (op == OP_DEC);
  assign commit_rd = (state == ST_EXEC && op != OP_STA) ||
                     (state == ST_DECODE && mode == MODE_IMM && is_read);
  assign res_zero = (alu_res == '0);

  // memory port steering
  always_comb begin
    mem_addr = pc;
    mem_we   = 1'b0;
    mem_wd   = a_r;
    unique case (state)
      ST_INDIR: mem_addr = opd;
      ST_EXEC: begin
        mem_addr = ea;
        if (op == OP_STA) begin
          mem_we = 1'b1;
          mem_wd = a_r;
        end else if (is_rmw) begin
          mem_we = 1'b1;
          mem_wd = alu_res;
        end
      end
      ST_DECODE: begin
        mem_addr = sp_r;
        if (op == OP_PHA) begin
          mem_we = 1'b1;
          mem_wd = a_r;
        end else if (op == OP_PHP) begin
          mem_we = 1'b1;
          mem_wd = psr;
        end else if (op == OP_JSR) begin
          mem_we = 1'b1;
          mem_wd = pc;
        end
      end
      ST_PULL: mem_addr = sp_r;
      default: mem_addr = pc;
    endcase
  end

  // ALU function and second operand
  always_comb begin
    unique case (op)
      OP_ADC:           alu_fn = ALU_ADD;
      OP_SBC:           alu_fn = ALU_SUB;
      OP_CMP:           alu_fn = ALU_CMP;
      OP_AND:           alu_fn = ALU_AND;
      OP_OR:            alu_fn = ALU_OR;
      OP_INC, OP_INCX:  alu_fn = ALU_INC;
      OP_DEC, OP_DECX:  alu_fn = ALU_DEC;
      default:          alu_fn = ALU_PASS;
    endcase
    unique case (op)
      OP_INCX, OP_DECX, OP_TXA: alu_b = x_r;
      OP_TAX:                   alu_b = a_r;
      OP_TSX:                   alu_b = sp_r;
      default:                  alu_b = (state == ST_DECODE) ? opd : mem_rd;
    endcase
  end

  acc8_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (mem_addr),
    .cpu_we    (mem_we),
    .cpu_wdata (mem_wd),
    .cpu_rdata (mem_rd),
    .ext_addr  (img_addr),
    .ext_we    (img_valid && img_ready),
    .ext_wdata (img_wdata),
    .ext_rdata (img_rdata)
  );

  acc8_alu #(.W(DW)) u_alu (
    .fn   (alu_fn),
    .a    (a_r),
    .b    (alu_b),
    .cin  (fc),
    .res  (alu_res),
    .cout (alu_c)
  );

  acc8_branch #(.W(DW)) u_br (
    .op      (op),
    .flag_c  (fc),
    .flag_z  (fz),
    .flag_n  (fn),
    .pc_next (pc),
    .offset  (opd),
    .taken   (br_taken),
    .target  (br_target)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FETCH_OP;
      pc    <= '0;
      ir    <= '0;
      opd   <= '0;
      ea    <= '0;
      a_r   <= '0;
      x_r   <= '0;
      sp_r  <= SP_INIT;
      fc    <= 1'b0;
      fz    <= 1'b0;
      fn    <= 1'b0;
    end else begin
      // results of reads, arithmetic and read-modify-write
      if (commit_rd) begin
        fz <= res_zero;
        fn <= alu_res[DW-1];
        unique case (op)
          OP_LDA, OP_AND, OP_OR: a_r <= alu_res;
          OP_LDX:                x_r <= alu_res;
          OP_ADC, OP_SBC: begin
            a_r <= alu_res;
            fc  <= alu_c;
          end
          OP_CMP:                fc  <= alu_c;
          default: ;
        endcase
      end

      unique case (state)
        ST_FETCH_OP: begin
          ir    <= mem_rd;
          pc    <= pc + 8'd1;
          state <= ST_FETCH_OPD;
        end
        ST_FETCH_OPD: begin
          opd   <= mem_rd;
          pc    <= pc + 8'd1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          state <= ST_FETCH_OP;
          unique case (op)
            OP_LDA, OP_LDX, OP_ADC, OP_SBC, OP_AND, OP_OR, OP_CMP,
            OP_STA, OP_INC, OP_DEC: begin
              unique case (mode)
                MODE_DIR: begin
                  ea    <= opd;
                  state <= ST_EXEC;
                end
                MODE_IDX: begin
                  ea    <= opd + x_r;
                  state <= ST_EXEC;
                end
                MODE_IND: state <= ST_INDIR;
                default:  if (!is_read) state <= ST_HALT;
              endcase
            end
            OP_INCX, OP_DECX, OP_TAX, OP_TSX: begin
              x_r <= alu_res;
              fz  <= res_zero;
              fn  <= alu_res[DW-1];
            end
            OP_TXA: begin
              a_r <= alu_res;
              fz  <= res_zero;
              fn  <= alu_res[DW-1];
            end
            OP_TXS:          sp_r <= x_r;
            OP_PHA, OP_PHP:  sp_r <= sp_r - 8'd1;
            OP_PLA, OP_PLP, OP_RTS: begin
              sp_r  <= sp_r + 8'd1;
              state <= ST_PULL;
            end
            OP_CLC: fc <= 1'b0;
            OP_SEC: fc <= 1'b1;
            OP_JMP: pc <= opd;
            OP_JSR: begin
              sp_r <= sp_r - 8'd1;
              pc   <= opd;
            end
            OP_BCC, OP_BCS, OP_BEQ, OP_BNE, OP_BMI, OP_BPL:
              if (br_taken) pc <= br_target;
            default: state <= ST_HALT;
          endcase
        end
        ST_INDIR: begin
          ea    <= mem_rd;
          state <= ST_EXEC;
        end
        ST_EXEC: state <= ST_FETCH_OP;
        ST_PULL: begin
          state <= ST_FETCH_OP;
          unique case (op)
            OP_PLA: begin
              a_r <= mem_rd;
              fz  <= (mem_rd == '0);
              fn  <= mem_rd[DW-1];
            end
            OP_PLP: begin
              fc <= mem_rd[PSR_C];
              fz <= mem_rd[PSR_Z];
              fn <= mem_rd[PSR_N];
            end
            default: pc <= mem_rd;
          endcase
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && $stable(a_r) && $stable(sp_r)));

  assert_no_write_halted_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  assert_fetch_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH_OP) |=> (pc == $past(pc) + 8'd1));

  assert_store_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && op == OP_STA) |=> ($stable(psr) && $stable(a_r)));

  assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_EXEC || state == ST_DECODE) && op == OP_CMP) |=> $stable(a_r));

  assert_push_moves_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && (op == OP_PHA || op == OP_PHP || op == OP_JSR)) |=>
      (sp_r == $past(sp_r) - 8'd1));

  assert_pull_moves_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && (op == OP_PLA || op == OP_PLP || op == OP_RTS)) |=>
      (sp_r == $past(sp_r) + 8'd1));
endmodule

// File: tb/sim_acc8_cpu.sv
module sim_acc8_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       img_valid = 1'b0;
  logic       img_ready;
  logic [7:0] img_addr = '0;
  logic [7:0] img_wdata = '0;
  logic [7:0] img_rdata;
  logic       halted;
  logic [7:0] acc_q, idx_q, sp_q, psr_q;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  acc8_cpu u0 (
    .clk(clk), .rst_n(rst_n), .img_valid(img_valid), .img_ready(img_ready),
    .img_addr(img_addr), .img_wdata(img_wdata), .img_rdata(img_rdata),
    .halted(halted), .acc_q(acc_q), .idx_q(idx_q), .sp_q(sp_q), .psr_q(psr_q)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] ad, input logic [7:0] d);
    @(negedge clk);
    img_valid = 1'b1;
    img_addr  = ad;
    img_wdata = d;
  endtask

  task automatic ins(input logic [7:0] ad, input logic [7:0] opc, input logic [7:0] arg);
    put(ad, opc);
    put(ad + 8'd1, arg);
  endtask

  task automatic peek(input logic [7:0] ad, output logic [7:0] v);
    @(negedge clk);
    img_valid = 1'b0;
    img_addr  = ad;
    #1 v = img_rdata;
  endtask

  task automatic chk_mem(input string req, input logic [7:0] ad, input logic [7:0] exp);
    logic [7:0] v;
    peek(ad, v);
    chk(req, $sformatf("mem[%02h]", ad), v, exp);
  endtask

  task automatic wipe();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) put(i[7:0], 8'h00);
  endtask

  // release reset, run to halt; optionally hammer the image port meanwhile
  task automatic run(input string req, input bit hammer);
    int n;
    @(negedge clk);
    img_valid = 1'b0;
    rst_n = 1'b1;
    if (hammer) begin
      img_valid = 1'b1;
      img_addr  = 8'h60;
      img_wdata = 8'hEE;
      repeat (6) @(negedge clk);
      img_valid = 1'b0;
    end
    n = 0;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "halted after run", {7'b0, halted}, 8'h01);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "A at reset", acc_q, 8'h00);
    chk("R1", "X at reset", idx_q, 8'h00);
    chk("R1", "SP at reset", sp_q, 8'hFF);
    chk("R1", "status at reset", psr_q, 8'h00);
    chk("R1", "halted at reset", {7'b0, halted}, 8'h00);
    chk("R2", "ready in reset", {7'b0, img_ready}, 8'h01);
    wipe();
    ins(8'h00, 8'h07, 8'h21);  // LDA #21
    ins(8'h02, 8'h00, 8'h00);  // HLT
    @(negedge clk);
    img_valid = 1'b0;
    rst_n = 1'b1;
    #1 chk("R1", "ready drops after release", {7'b0, img_ready}, 8'h00);
    repeat (10) @(negedge clk);
    chk("R1", "first fetch from address 0", acc_q, 8'h21);
  endtask

  task automatic t_subroutine_loop();
    wipe();
    ins(8'h00, 8'h0B, 8'h03);  // LDX #3
    ins(8'h02, 8'h60, 8'h20);  // JSR 20
    ins(8'h04, 8'h0E, 8'h40);  // STA 40,X
    ins(8'h06, 8'h30, 8'h00);  // DECX
    ins(8'h08, 8'h74, 8'hFA);  // BNE -6
    ins(8'h0A, 8'h0C, 8'h50);  // STA 50
    ins(8'h0C, 8'h00, 8'h00);  // HLT
    ins(8'h20, 8'h54, 8'h00);  // CLC
    ins(8'h22, 8'h07, 8'h10);  // LDA #10
    ins(8'h24, 8'h13, 8'h25);  // ADC #25
    ins(8'h26, 8'h64, 8'h00);  // RTS
    run("R9", 1'b1);
    chk("R9", "A after subroutine", acc_q, 8'h35);
    chk("R11", "X counted down", idx_q, 8'h00);
    chk("R9", "SP balanced", sp_q, 8'hFF);
    chk("R8", "status after loop", psr_q, 8'h02);
    chk_mem("R9", 8'hFF, 8'h04);
    chk_mem("R8", 8'h43, 8'h35);
    chk_mem("R8", 8'h42, 8'h35);
    chk_mem("R8", 8'h41, 8'h35);
    chk_mem("R8", 8'h40, 8'h00);
    chk_mem("R8", 8'h50, 8'h35);
    chk_mem("R2", 8'h60, 8'h00);  // write attempt while running
    put(8'h60, 8'h5C);
    chk_mem("R2", 8'h60, 8'h5C);  // write accepted once halted
  endtask

  task automatic t_modes();
    wipe();
    put(8'h80, 8'h11); put(8'h81, 8'h90); put(8'h82, 8'h22);
    put(8'h83, 8'h84); put(8'h84, 8'h0C);
    ins(8'h00, 8'h04, 8'h80);  // LDA 80
    ins(8'h02, 8'h0D, 8'h81);  // STA (81)
    ins(8'h04, 8'h0B, 8'h02);  // LDX #2
    ins(8'h06, 8'h06, 8'h80);  // LDA 80,X
    ins(8'h08, 8'h1D, 8'h83);  // OR (83)
    ins(8'h0A, 8'h0C, 8'h91);  // STA 91
    ins(8'h0C, 8'h00, 8'h00);
    run("R4", 1'b0);
    chk_mem("R4", 8'h90, 8'h11);
    chk_mem("R4", 8'h91, 8'h2E);
    chk("R4", "A after modes", acc_q, 8'h2E);
    chk("R4", "status after modes", psr_q, 8'h00);
  endtask

  task automatic t_arith();
    wipe();
    ins(8'h00, 8'h58, 8'h00);  // SEC
    ins(8'h02, 8'h07, 8'hF0);  // LDA #F0
    ins(8'h04, 8'h13, 8'h0F);  // ADC #0F
    ins(8'h06, 8'h4C, 8'h00);  // PHP
    ins(8'h08, 8'h0C, 8'hA0);  // STA A0
    ins(8'h0A, 8'h54, 8'h00);  // CLC
    ins(8'h0C, 8'h07, 8'h05);  // LDA #5
    ins(8'h0E, 8'h17, 8'h03);  // SBC #3
    ins(8'h10, 8'h0C, 8'hA1);  // STA A1
    ins(8'h12, 8'h17, 8'h02);  // SBC #2
    ins(8'h14, 8'h0C, 8'hA2);  // STA A2
    ins(8'h16, 8'h00, 8'h00);
    run("R5", 1'b0);
    chk_mem("R5", 8'hFF, 8'h03);
    chk_mem("R5", 8'hA0, 8'h00);
    chk_mem("R5", 8'hA1, 8'h01);
    chk_mem("R5", 8'hA2, 8'hFF);
    chk("R5", "status after borrow", psr_q, 8'h80);
    chk("R10", "SP after one push", sp_q, 8'hFE);
  endtask

  task automatic t_flags();
    wipe();
    put(8'hB0, 8'hFF);
    ins(8'h00, 8'h07, 8'h40);  // LDA #40
    ins(8'h02, 8'h23, 8'h40);  // CMP #40
    ins(8'h04, 8'h4C, 8'h00);  // PHP
    ins(8'h06, 8'h23, 8'h41);  // CMP #41
    ins(8'h08, 8'h4C, 8'h00);  // PHP
    ins(8'h0A, 8'h1B, 8'h0F);  // AND #0F
    ins(8'h0C, 8'h4C, 8'h00);  // PHP
    ins(8'h0E, 8'h24, 8'hB0);  // INC B0
    ins(8'h10, 8'h28, 8'hB1);  // DEC B1
    ins(8'h12, 8'h4C, 8'h00);  // PHP
    ins(8'h14, 8'h1F, 8'h81);  // OR #81
    ins(8'h16, 8'h23, 8'h81);  // CMP #81
    ins(8'h18, 8'h0C, 8'hB2);  // STA B2
    ins(8'h1A, 8'h4C, 8'h00);  // PHP
    ins(8'h1C, 8'h00, 8'h00);
    run("R6", 1'b0);
    chk_mem("R6", 8'hFF, 8'h03);
    chk_mem("R6", 8'hFE, 8'h80);
    chk_mem("R7", 8'hFD, 8'h02);
    chk_mem("R7", 8'hFC, 8'h80);
    chk_mem("R7", 8'hFB, 8'h03);  // store kept Z=1 with nonzero A
    chk_mem("R7", 8'hB0, 8'h00);
    chk_mem("R7", 8'hB1, 8'hFF);
    chk_mem("R7", 8'hB2, 8'h81);
    chk("R6", "A kept by compare", acc_q, 8'h81);
    chk("R10", "SP after five pushes", sp_q, 8'hFA);
  endtask

  task automatic t_stack();
    wipe();
    ins(8'h00, 8'h0B, 8'h80);  // LDX #80
    ins(8'h02, 8'h40, 8'h00);  // TXS
    ins(8'h04, 8'h07, 8'h5A);  // LDA #5A
    ins(8'h06, 8'h44, 8'h00);  // PHA
    ins(8'h08, 8'h07, 8'h00);  // LDA #0
    ins(8'h0A, 8'h48, 8'h00);  // PLA
    ins(8'h0C, 8'h0C, 8'hC0);  // STA C0
    ins(8'h0E, 8'h34, 8'h00);  // TAX
    ins(8'h10, 8'h2C, 8'h00);  // INCX
    ins(8'h12, 8'h3C, 8'h00);  // TSX
    ins(8'h14, 8'h38, 8'h00);  // TXA
    ins(8'h16, 8'h30, 8'h00);  // DECX
    ins(8'h18, 8'h58, 8'h00);  // SEC
    ins(8'h1A, 8'h4C, 8'h00);  // PHP
    ins(8'h1C, 8'h54, 8'h00);  // CLC
    ins(8'h1E, 8'h50, 8'h00);  // PLP
    ins(8'h20, 8'h00, 8'h00);
    run("R10", 1'b0);
    chk_mem("R10", 8'hC0, 8'h5A);
    chk_mem("R10", 8'h80, 8'h01);
    chk("R10", "status restored by pull", psr_q, 8'h01);
    chk("R11", "SP from TXS", sp_q, 8'h80);
    chk("R11", "A from TXA", acc_q, 8'h80);
    chk("R11", "X after TSX and DECX", idx_q, 8'h7F);
  endtask

  task automatic t_branches();
    wipe();
    ins(8'h00, 8'h07, 8'h00);  // LDA #0
    ins(8'h02, 8'h74, 8'h02);  // BNE +2 not taken
    ins(8'h04, 8'h70, 8'h02);  // BEQ +2 taken
    ins(8'h06, 8'h00, 8'h00);
    ins(8'h08, 8'h58, 8'hFF);  // SEC, junk operand
    ins(8'h0A, 8'h68, 8'h02);  // BCC not taken
    ins(8'h0C, 8'h6C, 8'h02);  // BCS taken
    ins(8'h0E, 8'h00, 8'h00);
    ins(8'h10, 8'h07, 8'h80);  // LDA #80
    ins(8'h12, 8'h7C, 8'h02);  // BPL not taken
    ins(8'h14, 8'h78, 8'h02);  // BMI taken
    ins(8'h16, 8'h00, 8'h00);
    ins(8'h18, 8'h5C, 8'h1E);  // JMP 1E
    ins(8'h1A, 8'h00, 8'h00);
    ins(8'h1C, 8'h00, 8'h00);
    ins(8'h1E, 8'h2C, 8'h77);  // INCX, junk operand
    ins(8'h20, 8'h0C, 8'hD0);  // STA D0
    ins(8'h22, 8'h00, 8'h00);
    run("R8", 1'b0);
    chk_mem("R8", 8'hD0, 8'h80);
    chk("R3", "implied operand ignored", idx_q, 8'h01);
    chk("R8", "status after branches", psr_q, 8'h01);
  endtask

  task automatic t_halt();
    wipe();
    ins(8'h00, 8'h07, 8'h33);  // LDA #33
    ins(8'h02, 8'h80, 8'h00);  // unused opcode
    ins(8'h04, 8'h07, 8'h44);
    ins(8'h06, 8'h00, 8'h00);
    run("R12", 1'b0);
    repeat (20) @(negedge clk);
    chk("R12", "still halted", {7'b0, halted}, 8'h01);
    chk("R12", "A frozen at halt", acc_q, 8'h33);
    chk("R2", "ready while halted", {7'b0, img_ready}, 8'h01);
    wipe();
    ins(8'h00, 8'h07, 8'h12);  // LDA #12
    ins(8'h02, 8'h0F, 8'h30);  // store in immediate mode
    ins(8'h04, 8'h07, 8'h99);
    ins(8'h06, 8'h00, 8'h00);
    run("R12", 1'b0);
    chk("R12", "immediate store stops", acc_q, 8'h12);
    chk_mem("R12", 8'h30, 8'h00);
  endtask

  initial begin
    t_reset();
    t_subroutine_loop();
    t_modes();
    t_arith();
    t_flags();
    t_stack();
    t_branches();
    t_halt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule